// File: doc/BRIEF.md
# CPU Clock Source Switch

This block picks the clock that a CPU runs on from two sources: a slow clock stepped by a supervising microcontroller, and a free-running fast oscillator. The CPU chooses the source itself. A decoded, data-strobe-qualified access to one address asks for the fast source, and an access to a second address asks for the slow one. The decoding happens outside the block and reaches it as two strobe pins. No data value is involved.

The selection flag opens one of two per-source gates. A disabled source is forced high, and the two gated clocks are ANDed into a merged clock. The merged clock drives a divide-by-two toggle flip-flop, and the toggle flip-flop's output is the CPU clock. The flag only changes on a falling edge of the merged clock. The toggle flip-flop only moves on rising edges. Because of this, every CPU clock phase spans the full time between two merged rising edges. A runt pulse at the moment of a switch therefore never reaches the CPU as a sliver.

With a fast oscillator of about 12 MHz, the CPU runs at about 6 MHz. Reset returns the block to the slow source so that the microcontroller keeps control of the CPU.

Top module: `cpu_clk_switch`

## Requirements
- R1: While `rst` is high, `cpu_clk` is held low. The first merged edge sampled after `rst` falls finds the slow source selected.
- R2: With the slow source selected, `cpu_clk` toggles on each rising edge of `clk_slow`, so its period is two `clk_slow` periods.
- R3: A fast strobe, active low by default (`stb_fast_n` = 0), switches the selection to the fast source. `cpu_clk` then has a period of two `clk_fast` periods.
- R4: A slow strobe (`stb_slow_n` = 0) switches the selection back to the slow source, and the `cpu_clk` period returns to two `clk_slow` periods.
- R5: When both strobes are active together, the slow source wins.
- R6: With no strobe active, the selection keeps its value indefinitely. A repeated fast strobe while the fast source is already selected leaves the fast rate unchanged.
- R7: Raising `rst` while the fast source is selected holds `cpu_clk` low. Once `rst` falls, the CPU clock resumes at the slow rate.
- R8: No high or low phase of `cpu_clk` is shorter than half a `clk_fast` period, whatever the timing of a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock stepped by the supervising microcontroller |
| clk_fast | input | 1 | Free-running fast oscillator |
| rst | input | 1 | Active-high reset; forces the slow source and holds the divider |
| stb_fast_n | input | 1 | Decoded fast-select strobe, active low by default |
| stb_slow_n | input | 1 | Decoded slow-select strobe, active low by default |
| cpu_clk | output | 1 | Divided, registered CPU clock |

## Verification
The bench builds the block with the default active-low strobe polarity. It runs a 20 ns fast oscillator against a 147.4 ns slow clock whose phase is offset, so that no edge of the two sources ever coincides. Strobe and reset changes are placed at random points off every clock edge. Across these switches the merged clock keeps meeting the old source's edges at changing offsets. That brings the worst case within reach, where the newly selected source is already high when the flag changes. It also brings within reach the zero-width low runt that the toggle stage must absorb while still keeping each CPU clock phase at least half a fast period long.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_FAST = 1'b1
  } clk_src_e;
endpackage

// File: rtl/cks_select.sv
module cks_select
  import cks_pkg::*;
#(
  parameter bit STB_ACT_LOW = 1'b1
) (
  input  logic     mclk,
  input  logic     rst,
  input  logic     stb_fast,
  input  logic     stb_slow,
  output clk_src_e src
);
  logic fast_req;
  logic slow_req;

  generate
    if (STB_ACT_LOW) begin : g_act_low
      assign fast_req = ~stb_fast;
      assign slow_req = ~stb_slow;
    end else begin : g_act_high
      assign fast_req = stb_fast;
      assign slow_req = stb_slow;
    end
  endgenerate

  // The flag moves on the merged clock's falling edge, so the next
  // divider edge is always a full rising edge of whichever source is open.
  always_ff @(negedge mclk) begin
    if (rst || slow_req) begin
      src <= SRC_SLOW;
    end else if (fast_req) begin
      src <= SRC_FAST;
    end
  end

  AST_RESET_SLOW: assert property (@(negedge mclk) disable iff (rst)
    $fell(rst) |-> (src == SRC_SLOW)); // R1
  AST_GO_FAST: assert property (@(negedge mclk) disable iff (rst)
    (fast_req && !slow_req) |=> (src == SRC_FAST)); // R3
  AST_GO_SLOW: assert property (@(negedge mclk) disable iff (rst)
    slow_req |=> (src == SRC_SLOW)); // R5
  AST_HOLD_SEL: assert property (@(negedge mclk) disable iff (rst)
    (!fast_req && !slow_req) |=> $stable(src)); // R6
endmodule

// File: rtl/cks_gate_merge.sv
module cks_gate_merge
  import cks_pkg::*;
(
  input  logic     clk_slow,
  input  logic     clk_fast,
  input  clk_src_e src,
  output logic     mclk
);
  logic en_slow;
  logic gated_slow;
  logic gated_fast;

  // A closed gate parks its source high, so the AND merge follows the open one.
  always_comb begin
    en_slow    = (src == SRC_SLOW);
    gated_slow = clk_slow | ~en_slow;
    gated_fast = clk_fast | en_slow;
    mclk       = gated_slow & gated_fast;
  end
endmodule

// File: rtl/cks_toggle.sv
module cks_toggle (
  input  logic mclk,
  input  logic rst,
  output logic q
);
  always_ff @(posedge mclk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      q <= ~q;
    end
  end

  AST_DIV_HELD_LOW: assert property (@(posedge mclk) disable iff (rst)
    $fell(rst) |-> (q == 1'b0)); // R1
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import cks_pkg::*;
#(
  parameter bit STB_ACT_LOW = 1'b1
) (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic rst,
  input  logic stb_fast_n,
  input  logic stb_slow_n,
  output logic cpu_clk
);
  clk_src_e src;
  logic     mclk;

  cks_select #(
    .STB_ACT_LOW(STB_ACT_LOW)
  ) i_select (
    .mclk    (mclk),
    .rst     (rst),
    .stb_fast(stb_fast_n),
    .stb_slow(stb_slow_n),
    .src     (src)
  );

  cks_gate_merge i_merge (
    .clk_slow(clk_slow),
    .clk_fast(clk_fast),
    .src     (src),
    .mclk    (mclk)
  );

  cks_toggle i_div (
    .mclk(mclk),
    .rst (rst),
    .q   (cpu_clk)
  );
endmodule

// File: tb/test_cpu_clk_switch.sv
`timescale 1ns/10ps
module test_cpu_clk_switch;
  localparam real T_FAST = 20.0;
  localparam real T_SLOW = 147.4;
  localparam real P_FAST = 2.0 * T_FAST;
  localparam real P_SLOW = 2.0 * T_SLOW;
  localparam real TOL    = 0.05;

  logic clk_slow = 1'b0;
  logic clk_fast = 1'b0;
  logic rst = 1'b1;
  logic stb_fast_n = 1'b1;
  logic stb_slow_n = 1'b1;
  logic cpu_clk;

  int checks = 0;
  int errors = 0;
  real exp_q[$];
  string tag_q[$];
  real min_phase = 1.0e9;
  real last_edge = -1.0;
  bit armed = 1'b0;

  cpu_clk_switch i_cpu_clk_switch (
    .clk_slow  (clk_slow),
    .clk_fast  (clk_fast),
    .rst       (rst),
    .stb_fast_n(stb_fast_n),
    .stb_slow_n(stb_slow_n),
    .cpu_clk   (cpu_clk)
  );

  initial forever #(T_FAST / 2.0) clk_fast = ~clk_fast;
  initial begin
    #0.35;
    forever #(T_SLOW / 2.0) clk_slow = ~clk_slow;
  end

  task automatic check_real(string tag, real act, real exp);
    checks++;
    if (act < exp - TOL || act > exp + TOL) begin
      errors++;
      $display("FAIL %s: actual=%0.2f expected=%0.2f", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each queued item is one expected CPU clock period.
  initial forever begin
    real t0;
    real t1;
    while (exp_q.size() == 0) @(posedge clk_fast);
    @(posedge cpu_clk) t0 = $realtime;
    @(posedge cpu_clk) t1 = $realtime;
    check_real(tag_q[0], t1 - t0, exp_q[0]);
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  // Phase-width watcher for R8.
  initial forever begin
    @(cpu_clk);
    if (armed && last_edge >= 0.0 && ($realtime - last_edge) < min_phase)
      min_phase = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic expect_periods(real p, string tag, int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(p);
      tag_q.push_back(tag);
    end
    while (exp_q.size() != 0) @(posedge clk_fast);
  endtask

  task automatic pulse(bit fast, bit slow);
    @(posedge clk_fast);
    #(0.3 + $urandom_range(0, 150));
    if (fast) stb_fast_n = 1'b0;
    if (slow) stb_slow_n = 1'b0;
    #450;
    stb_fast_n = 1'b1;
    stb_slow_n = 1'b1;
    repeat (4) @(posedge cpu_clk);
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20) @(posedge clk_fast);
    #3.3 check_bit("R1 reset holds cpu_clk low", cpu_clk, 1'b0);
    repeat (7) @(posedge clk_fast);
    #3.3 check_bit("R1 reset holds cpu_clk low later", cpu_clk, 1'b0);
    @(posedge clk_fast);
    #0.3 rst = 1'b0;
    armed = 1'b1;
    expect_periods(P_SLOW, "R2 slow rate after reset", 3);

    for (int i = 0; i < 12; i++) begin
      pulse(1'b1, 1'b0);
      expect_periods(P_FAST, "R3 fast rate", 2);
      if (i == 3) begin
        #2000;
        expect_periods(P_FAST, "R6 idle keeps fast", 2);
      end
      if (i == 5) begin
        pulse(1'b1, 1'b0);
        expect_periods(P_FAST, "R6 repeated fast strobe", 1);
      end
      pulse(1'b0, 1'b1);
      expect_periods(P_SLOW, "R4 back to slow", 2);
      if (i == 7) begin
        #3000;
        expect_periods(P_SLOW, "R6 idle keeps slow", 1);
      end
    end

    pulse(1'b1, 1'b0);
    expect_periods(P_FAST, "R5 setup fast", 1);
    pulse(1'b1, 1'b1);
    expect_periods(P_SLOW, "R5 both strobes pick slow", 2);

    pulse(1'b1, 1'b0);
    expect_periods(P_FAST, "R7 setup fast", 1);
    @(posedge clk_fast);
    #0.3 rst = 1'b1;
    #600;
    check_bit("R7 reset from fast holds low", cpu_clk, 1'b0);
    @(posedge clk_fast);
    #0.3 rst = 1'b0;
    expect_periods(P_SLOW, "R7 slow after reset", 2);

    check_real("R8 shortest phase at least half fast period",
               (min_phase >= T_FAST / 2.0 - TOL) ? T_FAST / 2.0 : min_phase,
               T_FAST / 2.0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule